// File: doc/BRIEF.md
# Sixteen-Bit I2C Port Expander Target

This block is an I2C target that maps a 16-bit quasi-bidirectional I/O port straight onto the bus. It has no pointer, configuration or status register. After its address byte, every data byte either goes to the port output latch or returns the current pin levels. Writes arrive in byte pairs: the first byte of a pair holds port bits 7..0 and the second holds bits 15..8. The latch takes the whole 16-bit value at once, only after the second byte has been acknowledged.

SCL and SDA are oversampled by the system clock through two-flop synchronizers. START and STOP are recognised from SDA edges while SCL is high. The target pulls SDA low through an open-drain enable. Three strap inputs form the low address bits, so up to eight devices can share a bus.

A per-bit strong-pullup enable gives a one-shot boost when a bit is written high. The boost ends at the next falling SCL edge. Analog drive, pads and power-on detection are outside the block; the asynchronous reset stands in for power-on.

Top module: `pex16_target`

## Requirements
- R1: While reset is held and after it is released, port_o is 16'hFFFF, pull_strong_o is 0 and sda_oe_o is 0.
- R2: The target acknowledges an address byte, sent MSB first, whose upper seven bits equal {4'b0100, addr_strap_i[2:0]}. The byte's LSB selects the mode: 0 writes to the port and 1 reads from it.
- R3: On an address mismatch the target leaves SDA released during the acknowledge bit. It ignores all further bytes of that transfer, so port_o stays unchanged and SDA is never driven.
- R4: In a write, data bytes are MSB first. The first byte of each pair goes to port bits 7..0 and the second to bits 15..8. port_o changes only at the falling SCL edge that ends the second byte's acknowledge, and any number of pairs may follow one address.
- R5: Every data byte of an addressed write is acknowledged, with SDA held low for the whole acknowledge clock.
- R6: In a read, the target sends pin_i bits 7..0 and then bits 15..8, MSB first, alternating for as long as the controller acknowledges. Each byte is sampled at the falling SCL edge that starts it.
- R7: A not-acknowledge from the controller after a read byte ends the transfer. SDA stays released until the next START.
- R8: When a pair is committed, pull_strong_o becomes the committed value, so only bits written high are set. It clears to 0 at the next falling SCL edge.
- R9: A STOP or a repeated START abandons a half-received pair. port_o keeps its value, and the next data byte is again treated as bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on stand-in) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap_i | input | 3 | Low three address bits |
| pin_i | input | 16 | Sampled port pin levels |
| port_o | output | 16 | Port output latch |
| pull_strong_o | output | 16 | Per-bit one-shot strong pullup enable |

## Verification
The bench goes after pair alignment. It stops or restarts in the middle of a pair and then writes a full pair: a design that kept the stray byte would show the wrong half bytes on port_o. It checks that port_o holds its value after the first byte of a pair, which catches a latch that updates one byte at a time. It also checks that the pullup mask drops at the first clock of the next byte, which catches a pulse that runs too long. Read tests alternate halves over several bytes and end with a not-acknowledge. Extra clocks then confirm the target no longer drives SDA, which catches a read engine that keeps running. A wrong strap address must get no acknowledge and must leave the port untouched.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int BYTE_W = 8;
  localparam int PORT_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_ACK_R
  } pex_state_e;
endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain[0] <= '1;
    else         chain[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= '1;
      else         chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pex_engine.sv
module pex_engine
  import pex_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic [PORT_W-1:0] rd_port_i,
  output logic              sda_oe_o,
  output logic              commit_o,
  output logic [PORT_W-1:0] commit_data_o,
  output logic              scl_fall_o,
  output logic              idle_o
);
  pex_state_e        st;
  logic              scl_q, sda_q, rw, hi_half;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, rb, lo_hold, nxt_rd;
  logic              rise, start_c, stop_c;

  assign rise       = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_c    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c     = scl_i & scl_q & ~sda_q & sda_i;
  assign nxt_rd     = hi_half ? rd_port_i[PORT_W-1:BYTE_W] : rd_port_i[BYTE_W-1:0];
  assign idle_o     = (st == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1; sda_q <= 1'b1; st <= ST_IDLE; cnt <= '0;
      sh <= '0; rb <= '0; lo_hold <= '0; hi_half <= 1'b0; rw <= 1'b0;
      sda_oe_o <= 1'b0; commit_o <= 1'b0; commit_data_o <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      commit_o <= 1'b0;
      if (start_c) begin
        st <= ST_ADDR; cnt <= '0; hi_half <= 1'b0; sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; hi_half <= 1'b0; sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_o && cnt == CNT_W'(BYTE_W)) begin
              if (sh[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
                st       <= ST_ACK_A;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_WR: begin
            if (rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_o && cnt == CNT_W'(BYTE_W)) begin
              sda_oe_o <= 1'b1;
              st       <= ST_ACK_W;
            end
          end
          ST_ACK_W: begin
            if (scl_fall_o) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              st       <= ST_WR;
              hi_half  <= ~hi_half;
              if (hi_half) begin
                commit_o      <= 1'b1;
                commit_data_o <= {sh, lo_hold};
              end else begin
                lo_hold <= sh;
              end
            end
          end
          ST_RD: begin
            if (scl_fall_o) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe_o <= 1'b0;
                st       <= ST_ACK_R;
              end else begin
                rb       <= {rb[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~rb[BYTE_W-2];
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_A, ST_ACK_R: begin
            if (st == ST_ACK_R && rise && sda_i) begin
              st <= ST_IDLE;  // controller NACK
            end else if (scl_fall_o) begin
              if (st == ST_ACK_A && !rw) begin
                sda_oe_o <= 1'b0;
                cnt      <= '0;
                st       <= ST_WR;
              end else begin
                rb       <= nxt_rd;
                sda_oe_o <= ~nxt_rd[BYTE_W-1];
                cnt      <= CNT_W'(1);
                hi_half  <= ~hi_half;
                st       <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pex_port.sv
module pex_port
  import pex_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PORT_W-1:0] data_i,
  input  logic              scl_fall_i,
  output logic [PORT_W-1:0] port_o,
  output logic [PORT_W-1:0] pull_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o <= '1;
      pull_o <= '0;
    end else if (commit_i) begin
      port_o <= data_i;
      pull_o <= data_i;
    end else if (scl_fall_i) begin
      pull_o <= '0;
    end
  end
endmodule

// File: rtl/pex16_target.sv
module pex16_target
  import pex_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [2:0]  addr_strap_i,
  input  logic [15:0] pin_i,
  output logic [15:0] port_o,
  output logic [15:0] pull_strong_o
);
  logic [1:0]        bus_s;
  logic              commit, scl_fall, bus_idle;
  logic [PORT_W-1:0] commit_data;

  pex_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  pex_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(bus_s[1]), .sda_i(bus_s[0]),
    .strap_i(addr_strap_i), .rd_port_i(pin_i), .sda_oe_o(sda_oe_o),
    .commit_o(commit), .commit_data_o(commit_data),
    .scl_fall_o(scl_fall), .idle_o(bus_idle)
  );

  pex_port u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .data_i(commit_data),
    .scl_fall_i(scl_fall), .port_o(port_o), .pull_o(pull_strong_o)
  );
endmodule

// File: rtl/pex16_target_chk.sv
module pex16_target_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] port_o,
  input logic [15:0] pull_strong_o,
  input logic        sda_oe_o,
  input logic        commit_i,
  input logic        scl_fall_i,
  input logic        idle_i
);
  // R4
  port_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_o) |-> $past(commit_i));
  // R8
  pull_high_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_strong_o & ~port_o) == 16'h0);
  // R8
  pull_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_fall_i) && !$past(commit_i)) |-> pull_strong_o == 16'h0);
  // R5
  ack_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));
  // R3
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_o);
endmodule

bind pex16_target pex16_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_o(port_o),
  .pull_strong_o(pull_strong_o), .sda_oe_o(sda_oe_o),
  .commit_i(commit), .scl_fall_i(scl_fall), .idle_i(bus_idle)
);

// File: tb/sim_pex16_target.sv
module sim_pex16_target;
  localparam int Q = 8;
  localparam int LIMIT = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl = 1'b1, sda_drv = 1'b1;
  logic [2:0]  strap = 3'd0;
  logic [15:0] pin = 16'h0;
  logic        sda_oe_o;
  logic [15:0] port_o, pull_strong_o;
  wire         sda_bus = sda_drv & ~sda_oe_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_port = 16'hFFFF;

  always #2 clk_i = ~clk_i;

  pex16_target u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe_o), .addr_strap_i(strap), .pin_i(pin),
    .port_o(port_o), .pull_strong_o(pull_strong_o)
  );

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0100, s, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_drv = b; wq(); scl = 1'b1; wq(); s = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic ack_it, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~ack_it, s);
  endtask

  task automatic wr_pair(input logic [15:0] v, input bit chk_pull);
    logic ack;
    wr_byte(v[7:0], ack);
    chk(ack, "R5 low byte ack", {31'd0, ack}, 1);
    chk(port_o == exp_port, "R4 no update after first byte", port_o, exp_port);
    wr_byte(v[15:8], ack);
    chk(ack, "R5 high byte ack", {31'd0, ack}, 1);
    exp_port = v;
    chk(port_o == exp_port, "R4 pair committed", port_o, exp_port);
    if (chk_pull) chk(pull_strong_o == v, "R8 pullup mask", pull_strong_o, v);
  endtask

  task automatic addr_w(input logic [2:0] s, input logic rd, output logic ack);
    bus_start();
    wr_byte(addr_byte(s, rd), ack);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h0000_5eed));
    strap = 3'($urandom);
    pin = 16'hBEEF;
    repeat (5) @(negedge clk_i);
    chk(port_o == 16'hFFFF, "R1 reset port", port_o, 16'hFFFF);
    chk(pull_strong_o == 16'h0, "R1 reset pull", pull_strong_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(port_o == 16'hFFFF && !sda_oe_o, "R1 after reset", {port_o, 15'd0, sda_oe_o}, 32'hFFFF0000);

    // R2 R4 R8: two pairs, pullup clears on next byte's first falling edge
    addr_w(strap, 1'b0, ack);
    chk(ack, "R2 address ack", {31'd0, ack}, 1);
    wr_pair(16'h3CA5, 1'b1);
    wr_byte(8'hFF, ack);
    chk(pull_strong_o == 16'h0, "R8 pullup cleared", pull_strong_o, 0);
    chk(port_o == exp_port, "R4 hold during second pair", port_o, exp_port);
    wr_byte(8'h00, ack);
    exp_port = 16'h00FF;
    chk(port_o == exp_port, "R4 second pair", port_o, exp_port);
    bus_stop();

    // R9: half pair abandoned by STOP
    addr_w(strap, 1'b0, ack);
    wr_byte(8'h12, ack);
    bus_stop();
    wq();
    chk(port_o == exp_port, "R9 stop drops half pair", port_o, exp_port);
    addr_w(strap, 1'b0, ack);
    wr_pair(16'h5634, 1'b1);
    bus_stop();

    // R9: half pair abandoned by repeated START
    addr_w(strap, 1'b0, ack);
    wr_byte(8'h77, ack);
    addr_w(strap, 1'b0, ack);
    chk(ack, "R9 restart address ack", {31'd0, ack}, 1);
    wr_pair(16'h2211, 1'b1);
    bus_stop();

    // R3: wrong strap
    addr_w(strap ^ 3'd1, 1'b0, ack);
    chk(!ack, "R3 mismatch no ack", {31'd0, ack}, 0);
    wr_byte(8'h00, ack);
    chk(!ack, "R3 data ignored", {31'd0, ack}, 0);
    wr_byte(8'h00, ack);
    chk(port_o == exp_port, "R3 port unchanged", port_o, exp_port);
    bus_stop();

    // R6 R7: read alternation, NACK, then released
    addr_w(strap, 1'b1, ack);
    chk(ack, "R2 read address ack", {31'd0, ack}, 1);
    for (int k = 0; k < 4; k++) begin
      rd_byte(k != 3, d);
      chk(d == ((k % 2 == 0) ? pin[7:0] : pin[15:8]), "R6 read byte", d,
          (k % 2 == 0) ? pin[7:0] : pin[15:8]);
    end
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    bus_stop();

    // random mix
    for (int it = 0; it < 30; it++) begin
      int n;
      n = 1 + int'($urandom % 3);
      if ($urandom % 2 == 0) begin
        addr_w(strap, 1'b0, ack);
        chk(ack, "R2 random write address", {31'd0, ack}, 1);
        for (int p = 0; p < n; p++) wr_pair(16'($urandom), 1'b1);
      end else begin
        pin = 16'($urandom);
        addr_w(strap, 1'b1, ack);
        chk(ack, "R2 random read address", {31'd0, ack}, 1);
        for (int k = 0; k < 2 * n; k++) begin
          rd_byte(k != 2 * n - 1, d);
          chk(d == ((k % 2 == 0) ? pin[7:0] : pin[15:8]), "R6 random read", d,
              (k % 2 == 0) ? pin[7:0] : pin[15:8]);
        end
      end
      bus_stop();
      wq();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule